// File: doc/BRIEF.md
# PHY Link Status and False-Carrier Counter Registers

This block is a slice of the management register file of a 10/100 Ethernet PHY. It reads live condition signals from the PHY core: link up, jabber, remote fault received during auto-negotiation, auto-negotiation enabled and complete, loopback, duplex, speed and a one-cycle false-carrier event pulse. It presents two registers on a simple parallel read/write port. The first is a read-only link status word. The second holds a saturating 8-bit count of false-carrier events.

The status word shows most conditions live. Remote fault is the exception: it is held as a sticky copy. Reading the status word never clears anything. The sticky remote-fault copy is released only by a read of the basic status address (0x01). At that address this slice drives zero read data, because the word itself comes from another slice; the read only triggers the clear. The event counter clears on read and can also be written.

Two small state machines hold the sticky state. The fault latch has the states `FLT_CLEAR` and `FLT_HELD`. It moves CLEAR→HELD when a remote fault is seen, and HELD→CLEAR on a read of 0x01 with no new fault in that cycle. The counter tracks `CNT_EMPTY`, `CNT_PARTIAL` and `CNT_FULL`. An event moves it EMPTY→PARTIAL, or PARTIAL→FULL when the count reaches 0xFF. A read clears it to EMPTY. A write moves it to whichever state matches the written value. FULL ignores further events.

Top module: `phy_status_regs`

## Requirements
- R1: After reset, the read data, the event count and the sticky remote-fault flag are all 0.
- R2: Read data is registered and appears one cycle after the read strobe. In cycles that follow no read, it is 0. A read of any address other than 0x01, 0x10 or 0x14 returns 0 and changes no state.
- R3: At address 0x10, bit 0 shows link up, bit 3 shows loopback and bit 4 shows auto-negotiation complete, all live. Reading 0x10 clears nothing.
- R4: Bit 2 (1 = full duplex) and bit 1 (1 = 10 Mb/s) of 0x10 follow their inputs only while the link is up and auto-negotiation is either complete or disabled. Otherwise they read 0.
- R5: Bit 5 of 0x10 shows jabber, and only while the 10 Mb/s input is 1. Otherwise it reads 0.
- R6: Bit 6 of 0x10 is set by a remote-fault input and stays set after that input drops. A read of 0x10 does not clear it. A read of 0x01 (which returns 0) clears it.
- R7: A remote fault in the same cycle as a read of 0x01 leaves bit 6 set.
- R8: Bits 7:0 of 0x14 count false-carrier pulses one per cycle and hold at 0xFF.
- R9: A read of 0x14 returns the count and clears it to 0. An event in the same cycle is kept, so the next count starts at 1.
- R10: A write to 0x14 loads write-data bits 7:0. An event in the same cycle adds one, saturating at 0xFF. Writes to 0x10 have no effect. Bit 7 of 0x10 and bits 15:8 of both registers always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 5 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| link_up | input | 1 | Live link-valid condition |
| jabber | input | 1 | Live jabber condition |
| rem_fault | input | 1 | Remote fault signalled by the link partner |
| an_enable | input | 1 | Auto-negotiation enabled |
| an_done | input | 1 | Auto-negotiation complete |
| loopback | input | 1 | Loopback enabled |
| full_duplex | input | 1 | 1 = full duplex, 0 = half |
| speed10 | input | 1 | 1 = 10 Mb/s, 0 = 100 Mb/s |
| fc_event | input | 1 | One-cycle false-carrier event pulse |

## Verification
A wrong sticky flag or a wrong count stays hidden until the next read of 0x10 or 0x14. It then shows as a wrong bit one cycle after that read strobe. A lost clear or a spurious clear shows up on the read that follows. Gating errors on the duplex, speed and jabber bits appear only when the link and auto-negotiation inputs are in the states that should hide those bits. For that reason the bench walks those combinations and compares every cycle's read data against a behavioural model.

// File: rtl/phy_status_pkg.sv
package phy_status_pkg;
    localparam int REG_ADDR_W = 5;
    localparam int REG_DATA_W = 16;
    localparam int CNT_W      = 8;

    localparam logic [REG_ADDR_W-1:0] ADDR_BASIC  = 5'h01;
    localparam logic [REG_ADDR_W-1:0] ADDR_STATUS = 5'h10;
    localparam logic [REG_ADDR_W-1:0] ADDR_FCCNT  = 5'h14;

    typedef enum logic [1:0] {
        CNT_EMPTY   = 2'd0,
        CNT_PARTIAL = 2'd1,
        CNT_FULL    = 2'd2
    } cnt_state_t;

    typedef enum logic {
        FLT_CLEAR = 1'b0,
        FLT_HELD  = 1'b1
    } flt_state_t;

    typedef struct packed {
        logic link;
        logic jab;
        logic an_en;
        logic an_cmp;
        logic lpbk;
        logic fdx;
        logic spd10;
    } live_cond_t;
endpackage

// File: rtl/fault_latch.sv
module fault_latch
    import phy_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic held_o
);
    flt_state_t cur_st, nxt_st;

    always_ff @(posedge clk) begin
        if (!rst_n) cur_st <= FLT_CLEAR;
        else        cur_st <= nxt_st;
    end

    always_comb begin
        nxt_st = cur_st;
        unique case (cur_st)
            FLT_CLEAR: if (set_i) nxt_st = FLT_HELD;
            FLT_HELD:  if (clr_i && !set_i) nxt_st = FLT_CLEAR;
            default:   nxt_st = FLT_CLEAR;
        endcase
    end

    always_comb held_o = (cur_st == FLT_HELD);

    AST_FLT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> held_o); // R7
    AST_FLT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (held_o && !clr_i) |=> held_o); // R6
    AST_FLT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (held_o && clr_i && !set_i) |=> !held_o); // R6
endmodule

// File: rtl/fc_counter.sv
module fc_counter
    import phy_status_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         event_i,
    input  logic         clr_i,
    input  logic         wr_i,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] count_o
);
    localparam logic [W-1:0] MAX_CNT = {W{1'b1}};

    cnt_state_t    cur_st, nxt_st;
    logic [W-1:0]  cnt_q, base, nxt_cnt;
    logic          room;

    always_comb begin
        base = cnt_q;
        room = 1'b1;
        if (wr_i) begin
            base = wr_val;
            room = (wr_val != MAX_CNT);
        end else if (clr_i) begin
            base = '0;
            room = 1'b1;
        end else begin
            unique case (cur_st)
                CNT_EMPTY, CNT_PARTIAL: room = 1'b1;
                CNT_FULL:               room = 1'b0;
                default:                room = 1'b0;
            endcase
        end
        nxt_cnt = base + {{(W-1){1'b0}}, (event_i && room)};
        if (nxt_cnt == '0)          nxt_st = CNT_EMPTY;
        else if (nxt_cnt == MAX_CNT) nxt_st = CNT_FULL;
        else                        nxt_st = CNT_PARTIAL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_st <= CNT_EMPTY;
            cnt_q  <= '0;
        end else begin
            cur_st <= nxt_st;
            cnt_q  <= nxt_cnt;
        end
    end

    always_comb count_o = cnt_q;

    AST_CNT_STATE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == CNT_EMPTY) == (cnt_q == '0)); // R8
    AST_CNT_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == MAX_CNT && !wr_i && !clr_i) |=> cnt_q == MAX_CNT); // R8
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (event_i && !wr_i && !clr_i && cnt_q != MAX_CNT) |=> cnt_q == $past(cnt_q) + 1'b1); // R8
    AST_CNT_CLEAR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !wr_i) |=> cnt_q == {{(W-1){1'b0}}, $past(event_i)}); // R9
endmodule

// File: rtl/status_word.sv
module status_word
    import phy_status_pkg::*;
#(
    parameter int DW = REG_DATA_W
) (
    input  live_cond_t    cond_i,
    input  logic          fault_i,
    output logic [DW-1:0] word_o
);
    logic mode_ok;

    always_comb begin
        mode_ok   = cond_i.link && (cond_i.an_cmp || !cond_i.an_en);
        word_o    = '0;
        word_o[0] = cond_i.link;
        word_o[1] = mode_ok && cond_i.spd10;
        word_o[2] = mode_ok && cond_i.fdx;
        word_o[3] = cond_i.lpbk;
        word_o[4] = cond_i.an_cmp;
        word_o[5] = cond_i.jab && cond_i.spd10;
        word_o[6] = fault_i;
    end
endmodule

// File: rtl/phy_status_regs.sv
module phy_status_regs
    import phy_status_pkg::*;
#(
    parameter int AW = REG_ADDR_W,
    parameter int DW = REG_DATA_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic          link_up,
    input  logic          jabber,
    input  logic          rem_fault,
    input  logic          an_enable,
    input  logic          an_done,
    input  logic          loopback,
    input  logic          full_duplex,
    input  logic          speed10,
    input  logic          fc_event
);
    logic          hit_basic, hit_status, hit_cnt;
    logic          fault_held;
    logic [CW-1:0] count;
    logic [DW-1:0] sts_word, rd_mux;
    live_cond_t    cond;

    always_comb begin
        hit_basic  = (reg_addr == ADDR_BASIC[AW-1:0]);
        hit_status = (reg_addr == ADDR_STATUS[AW-1:0]);
        hit_cnt    = (reg_addr == ADDR_FCCNT[AW-1:0]);
        cond.link   = link_up;
        cond.jab    = jabber;
        cond.an_en  = an_enable;
        cond.an_cmp = an_done;
        cond.lpbk   = loopback;
        cond.fdx    = full_duplex;
        cond.spd10  = speed10;
    end

    fault_latch u_fault (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (rem_fault),
        .clr_i  (rd_en && hit_basic),
        .held_o (fault_held)
    );

    fc_counter #(.W(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .event_i (fc_event),
        .clr_i   (rd_en && hit_cnt),
        .wr_i    (wr_en && hit_cnt),
        .wr_val  (wr_data[CW-1:0]),
        .count_o (count)
    );

    status_word #(.DW(DW)) u_sts (
        .cond_i  (cond),
        .fault_i (fault_held),
        .word_o  (sts_word)
    );

    always_comb begin
        rd_mux = '0;
        if (hit_status)   rd_mux = sts_word;
        else if (hit_cnt) rd_mux[CW-1:0] = count;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
        else            rd_data <= '0;
    end

    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rd_data == '0); // R2
    AST_RSVD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DW-1:CW] == '0); // R10
    AST_STS_BIT7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit_status) |=> !rd_data[7]); // R10
    AST_STS_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit_status && fault_held) |=> fault_held); // R6
endmodule

// File: tb/sim_phy_status_regs.sv
module sim_phy_status_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [4:0]  reg_addr = 0;
    logic        rd_en = 0, wr_en = 0;
    logic [15:0] wr_data = 0;
    logic [15:0] rd_data;
    logic link_up = 0, jabber = 0, rem_fault = 0, an_enable = 0, an_done = 0;
    logic loopback = 0, full_duplex = 0, speed10 = 0, fc_event = 0;

    int checks = 0, errors = 0, cycles = 0;
    string cur_req = "R1";
    int m_cnt = 0;
    bit m_flt = 0;
    logic [15:0] m_rd = 0;
    logic [15:0] m_rv;
    int m_base;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_status_regs u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .rd_en(rd_en),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .link_up(link_up), .jabber(jabber), .rem_fault(rem_fault),
        .an_enable(an_enable), .an_done(an_done), .loopback(loopback),
        .full_duplex(full_duplex), .speed10(speed10), .fc_event(fc_event)
    );

    function automatic logic [15:0] model_sts(bit flt);
        logic [15:0] s;
        bit ok;
        ok = link_up && (an_done || !an_enable);
        s = 16'h0;
        if (link_up)               s = s | 16'h0001;
        if (ok && speed10)         s = s | 16'h0002;
        if (ok && full_duplex)     s = s | 16'h0004;
        if (loopback)              s = s | 16'h0008;
        if (an_done)               s = s | 16'h0010;
        if (jabber && speed10)     s = s | 16'h0020;
        if (flt)                   s = s | 16'h0040;
        return s;
    endfunction

    always @(posedge clk) begin
        cycles = cycles + 1;
        if (!rst_n) begin
            m_cnt = 0; m_flt = 0; m_rd = 0;
        end else begin
            m_rv = 16'h0;
            if (rd_en) begin
                if (reg_addr == 5'h10)      m_rv = model_sts(m_flt);
                else if (reg_addr == 5'h14) m_rv = 16'(m_cnt);
            end
            m_rd = m_rv;
            if (wr_en && reg_addr == 5'h14)      m_base = int'(wr_data[7:0]);
            else if (rd_en && reg_addr == 5'h14) m_base = 0;
            else                                 m_base = m_cnt;
            if (fc_event && m_base < 255) m_base = m_base + 1;
            m_cnt = m_base;
            m_flt = rem_fault || (m_flt && !(rd_en && reg_addr == 5'h01));
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [4:0] a, input logic r, input logic w,
                        input logic [15:0] d, input logic fc);
        reg_addr = a; rd_en = r; wr_en = w; wr_data = d; fc_event = fc;
        @(negedge clk);
        chk({cur_req, " model"}, rd_data, m_rd);
        rd_en = 0; wr_en = 0; fc_event = 0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [15:0] exp);
        step(a, 1, 0, 16'h0, 0);
        chk(req, rd_data, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        cur_req = "R1";
        chk("R1", rd_data, 16'h0);
        rd_chk("R1", 5'h14, 16'h0000);
        rd_chk("R1", 5'h10, 16'h0000);

        // R3: live bits, no clear on read
        cur_req = "R3";
        link_up = 1; an_enable = 1; an_done = 1; loopback = 1;
        rd_chk("R3", 5'h10, 16'h0019);
        rd_chk("R3", 5'h10, 16'h0019);

        // R4: duplex/speed gating
        cur_req = "R4";
        full_duplex = 1; speed10 = 1;
        rd_chk("R4", 5'h10, 16'h001F);
        an_done = 0;
        rd_chk("R4", 5'h10, 16'h0009);
        an_enable = 0;
        rd_chk("R4", 5'h10, 16'h000F);
        link_up = 0;
        rd_chk("R4", 5'h10, 16'h0008);

        // R5: jabber only in 10 Mb/s
        cur_req = "R5";
        link_up = 1; jabber = 1;
        rd_chk("R5", 5'h10, 16'h002F);
        speed10 = 0;
        rd_chk("R5", 5'h10, 16'h000D);
        jabber = 0; link_up = 0; loopback = 0; full_duplex = 0;
        rd_chk("R5", 5'h10, 16'h0000);

        // R6: sticky remote fault
        cur_req = "R6";
        rem_fault = 1; step(5'h00, 0, 0, 16'h0, 0); rem_fault = 0;
        rd_chk("R6", 5'h10, 16'h0040);
        rd_chk("R6", 5'h10, 16'h0040);
        rd_chk("R6", 5'h01, 16'h0000);
        rd_chk("R6", 5'h10, 16'h0000);

        // R7: fault coincident with clearing read
        cur_req = "R7";
        rem_fault = 1; step(5'h00, 0, 0, 16'h0, 0);
        step(5'h01, 1, 0, 16'h0, 0);
        rem_fault = 0;
        rd_chk("R7", 5'h10, 16'h0040);
        rd_chk("R7", 5'h01, 16'h0000);
        rd_chk("R7", 5'h10, 16'h0000);

        // R8: counting and saturation
        cur_req = "R8";
        for (int i = 0; i < 3; i++) step(5'h00, 0, 0, 16'h0, 1);
        rd_chk("R8", 5'h14, 16'h0003);
        rd_chk("R8", 5'h14, 16'h0000);
        for (int i = 0; i < 300; i++) step(5'h00, 0, 0, 16'h0, 1);
        rd_chk("R8", 5'h14, 16'h00FF);

        // R9: event during clearing read
        cur_req = "R9";
        for (int i = 0; i < 5; i++) step(5'h00, 0, 0, 16'h0, 1);
        step(5'h14, 1, 0, 16'h0, 1);
        chk("R9", rd_data, 16'h0005);
        rd_chk("R9", 5'h14, 16'h0001);

        // R10: writes and reserved bits
        cur_req = "R10";
        step(5'h14, 0, 1, 16'hABCD, 0);
        rd_chk("R10", 5'h14, 16'h00CD);
        step(5'h14, 0, 1, 16'h0010, 1);
        rd_chk("R10", 5'h14, 16'h0011);
        step(5'h14, 0, 1, 16'h00FF, 1);
        rd_chk("R10", 5'h14, 16'h00FF);
        step(5'h10, 0, 1, 16'hFFFF, 0);
        rd_chk("R10", 5'h10, 16'h0000);

        // R2: unmapped read, no side effect
        cur_req = "R2";
        step(5'h00, 0, 0, 16'h0, 1);
        step(5'h00, 0, 0, 16'h0, 1);
        rd_chk("R2", 5'h05, 16'h0000);
        chk("R2", rd_data, 16'h0000);
        step(5'h14, 0, 0, 16'h0, 0);
        chk("R2", rd_data, 16'h0000);
        rd_chk("R2", 5'h14, 16'h0002);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule